// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Queue

This block receives asynchronous serial characters. It works from a sixteen-times oversampling enable that is generated elsewhere. An idle-high line is watched for a falling edge. The start bit is confirmed half a bit later, and every following bit is sampled near its centre. The character is then assembled according to a three-bit frame mode.

Each completed character goes into a small first-in first-out queue. The queue stores the data together with two error tags: a parity flag and a framing flag. The consumer sees the oldest entry on a read port, already widened to a bus word, and a one-cycle read strobe removes it.

Status outputs report:
- whether the queue holds data, is at least half full, or is full;
- a sticky overrun condition;
- an idle timeout, measured in bit times, that prompts the consumer to drain a partly filled queue.

A flush strobe discards everything queued. A loopback select takes the local transmitter's output in place of the external pin, so the link can be tested without wiring.

Top module: `rx_tagged_fifo`

## Requirements
- R1: Characters are received only while both `cfg_rx_en` and `cfg_run` are high; with either low, activity on the line queues nothing and any frame in progress is abandoned.
- R2: A low level is taken as a start bit only if it is still low 8 oversampling ticks after the falling edge; a shorter low pulse queues nothing.
- R3: Data bits are sampled every 16 ticks after the start-bit centre, least significant bit first. In mode 3'b001 (and in the unused codes 3'b000, 3'b010, 3'b110) the frame has 8 data bits, the word carries them in bits [7:0], and bits [9:8] are 0 when the stop bit is high.
- R4: In mode 3'b011 the frame has 7 data bits and a parity bit. The word holds the data in bits [6:0] and the received parity bit in bit 7. Bit 8 is 1 when the XOR of the data and parity bits differs from `cfg_odd` (0 selects even parity, 1 selects odd parity).
- R5: In mode 3'b111 the frame has 8 data bits and a parity bit. The word holds the data in bits [7:0], and bit 8 is always 0, whatever parity was received.
- R6: In modes 3'b100 and 3'b101 the frame has 9 data bits, and bit 8 of the word is the ninth data bit.
- R7: A low stop bit sets bit 9 of the word. A break (line held low) yields exactly one word, with data 0 and bit 9 set, because after a framing error the receiver waits for the line to return high before it looks for another start bit.
- R8: Up to `FIFO_DEPTH` (16) words are held in arrival order. `rd_data` shows the oldest word, and `rd_en` removes it. `st_ready` is high when at least one word is held, `st_half` when at least half the depth is held, and `st_full` when all entries are used.
- R9: A character completed while the queue is full, with no read in the same cycle, is discarded and sets `st_overrun`. `st_overrun` stays high until a read that removes a word.
- R10: A `flush` pulse empties the queue and clears `st_overrun`, and takes priority over a character completed in the same cycle.
- R11: `st_timeout` is high when the queue holds data and the receiver has been idle for at least `cfg_timeout` bit times. The idle count restarts on every queued character and on every read.
- R12: With `cfg_loop` high, the receiver decodes `txd_loop` and ignores `rxd_pin`.
- R13: `rd_data` bits above 9 are always 0, and the whole word is 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd_pin | input | 1 | External serial line, idle high |
| txd_loop | input | 1 | Local transmitter output used in loopback |
| cfg_loop | input | 1 | Selects `txd_loop` as the receive line |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_run | input | 1 | Run enable |
| cfg_mode | input | 3 | Frame mode code |
| cfg_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_timeout | input | TMO_WIDTH | Idle timeout in bit times |
| rd_en | input | 1 | Removes the oldest word |
| flush | input | 1 | Empties the queue |
| rd_data | output | RD_WIDTH | Oldest word: data, parity flag bit 8, framing flag bit 9 |
| st_ready | output | 1 | Queue holds at least one word |
| st_half | output | 1 | Queue at least half full |
| st_full | output | 1 | Queue full |
| st_overrun | output | 1 | Sticky overrun |
| st_timeout | output | 1 | Idle timeout with data waiting |

## Verification
The bench targets three kinds of fault. First, a short low glitch: a receiver that starts on the edge alone would queue a spurious character. Second, a long break: a receiver that re-arms while the line is still low would queue a stream of zero words instead of one. Third, the parity bit in each mode: a design that checks parity in the 8-bit parity mode, or misplaces the received parity bit in the 7-bit mode, produces a different word.

The queue is driven past full. The bench then confirms that the extra characters vanish while the sixteen older ones come out in order, and that the overrun flag clears on the first read. The timeout is checked before and after a read restarts it. A design that does not restart the count on a read would raise the flag too early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Frame mode codes decoded by the sampler
    localparam logic [2:0] MODE_8   = 3'b001;
    localparam logic [2:0] MODE_7P  = 3'b011;
    localparam logic [2:0] MODE_9   = 3'b100;
    localparam logic [2:0] MODE_8W  = 3'b101;
    localparam logic [2:0] MODE_8P  = 3'b111;

    // Stored word layout
    localparam int WORD_W  = 10;
    localparam int BIT_PE  = 8;
    localparam int BIT_FE  = 9;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_PAR,
        RS_STOP,
        RS_HOLD
    } rx_state_e;

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_in,
    input  logic              enable,
    input  logic [2:0]        mode,
    input  logic              odd,
    output logic              char_valid,
    output logic [WORD_W-1:0] char_word,
    output logic              line_idle
);

    typedef struct packed {
        rx_state_e  st;
        logic [3:0] tcnt;
        logic [3:0] bidx;
        logic [8:0] sh;
        logic       par;
    } smp_t;

    smp_t q, d;
    logic [3:0] last_idx;
    logic       has_par;
    logic       emit;
    logic [WORD_W-1:0] word;

    always_comb begin
        case (mode)
            MODE_7P:        last_idx = 4'd6;
            MODE_9, MODE_8W: last_idx = 4'd8;
            default:        last_idx = 4'd7;
        endcase
        has_par = (mode == MODE_7P) || (mode == MODE_8P);
    end

    always_comb begin
        d    = q;
        emit = 1'b0;
        if (!enable) begin
            d.st   = RS_IDLE;
            d.tcnt = '0;
        end else if (tick) begin
            case (q.st)
                RS_IDLE: begin
                    if (!line_in) begin
                        d.st   = RS_START;
                        d.tcnt = '0;
                    end
                end
                RS_START: begin
                    if (q.tcnt == 4'd7) begin
                        d.tcnt = '0;
                        d.bidx = '0;
                        d.sh   = '0;
                        d.par  = 1'b0;
                        d.st   = line_in ? RS_IDLE : RS_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 4'd1;
                    end
                end
                RS_DATA: begin
                    if (q.tcnt == 4'd15) begin
                        d.tcnt = '0;
                        d.sh[q.bidx] = line_in;
                        if (q.bidx == last_idx) begin
                            d.st = has_par ? RS_PAR : RS_STOP;
                        end else begin
                            d.bidx = q.bidx + 4'd1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 4'd1;
                    end
                end
                RS_PAR: begin
                    if (q.tcnt == 4'd15) begin
                        d.tcnt = '0;
                        d.par  = line_in;
                        d.st   = RS_STOP;
                    end else begin
                        d.tcnt = q.tcnt + 4'd1;
                    end
                end
                RS_STOP: begin
                    if (q.tcnt == 4'd15) begin
                        d.tcnt = '0;
                        emit   = 1'b1;
                        d.st   = line_in ? RS_IDLE : RS_HOLD;
                    end else begin
                        d.tcnt = q.tcnt + 4'd1;
                    end
                end
                RS_HOLD: begin
                    if (line_in) d.st = RS_IDLE;
                end
                default: d.st = RS_IDLE;
            endcase
        end
    end

    // Word assembly from the collected bits; stop level taken at emit
    always_comb begin
        word = '0;
        case (mode)
            MODE_7P: begin
                word[6:0]    = q.sh[6:0];
                word[7]      = q.par;
                word[BIT_PE] = ((^q.sh[6:0]) ^ q.par) != odd;
            end
            MODE_8P: begin
                word[7:0]    = q.sh[7:0];
                word[BIT_PE] = 1'b0;
            end
            MODE_9, MODE_8W: begin
                word[8:0]    = q.sh;
            end
            default: begin
                word[7:0]    = q.sh[7:0];
            end
        endcase
        word[BIT_FE] = !line_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RS_IDLE, tcnt: '0, bidx: '0, sh: '0, par: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign char_valid = emit;
    assign char_word  = word;
    assign line_idle  = (q.st == RS_IDLE);

endmodule

// File: rtl/rx_queue.sv
module rx_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head_word,
    output logic [$clog2(DEPTH):0] count,
    output logic             overrun,
    output logic             did_pop
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
        logic        ovr;
    } qst_t;

    qst_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic empty, full, do_pop, do_push, drop;

    always_comb begin
        count   = q.wp - q.rp;
        empty   = (count == '0);
        full    = (count == (AW+1)'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && full && !do_pop;
        d = q;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.ovr = 1'b0;
        end else begin
            if (do_push) d.wp = q.wp + 1'b1;
            if (do_pop)  d.rp = q.rp + 1'b1;
            if (drop)        d.ovr = 1'b1;
            else if (do_pop) d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{wp: '0, rp: '0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[q.wp[AW-1:0]] <= push_word;
    end

    assign head_word = mem_q[q.rp[AW-1:0]];
    assign overrun   = q.ovr;
    assign did_pop   = do_pop;

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);

    typedef struct packed {
        logic [3:0]       sub;
        logic [CNT_W-1:0] bits;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.sub  = '0;
            d.bits = '0;
        end else if (idle && tick) begin
            d.sub = q.sub + 4'd1;
            if (q.sub == 4'd15 && q.bits != {CNT_W{1'b1}}) begin
                d.bits = q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sub: '0, bits: '0};
        end else begin
            q <= d;
        end
    end

    assign reached = (q.bits >= limit);

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rxf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RD_WIDTH   = 16,
    parameter int TMO_WIDTH  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rxd_pin,
    input  logic                 txd_loop,
    input  logic                 cfg_loop,
    input  logic                 cfg_rx_en,
    input  logic                 cfg_run,
    input  logic [2:0]           cfg_mode,
    input  logic                 cfg_odd,
    input  logic [TMO_WIDTH-1:0] cfg_timeout,
    input  logic                 rd_en,
    input  logic                 flush,
    output logic [RD_WIDTH-1:0]  rd_data,
    output logic                 st_ready,
    output logic                 st_half,
    output logic                 st_full,
    output logic                 st_overrun,
    output logic                 st_timeout
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam int HALF  = FIFO_DEPTH / 2;
    localparam int PAD_W = RD_WIDTH - WORD_W;

    typedef struct packed {
        logic [1:0] sync;
    } top_t;

    top_t q, d;
    logic              line_s;
    logic              ch_valid;
    logic [WORD_W-1:0] ch_word;
    logic              rx_idle;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic              ovr;
    logic              popped;
    logic              tmo_hit;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], cfg_loop ? txd_loop : rxd_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: 2'b11};
        else        q <= d;
    end

    assign line_s = q.sync[1];

    rx_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line_in    (line_s),
        .enable     (cfg_rx_en && cfg_run),
        .mode       (cfg_mode),
        .odd        (cfg_odd),
        .char_valid (ch_valid),
        .char_word  (ch_word),
        .line_idle  (rx_idle)
    );

    rx_queue #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ch_valid),
        .push_word (ch_word),
        .pop       (rd_en),
        .flush     (flush),
        .head_word (head),
        .count     (fill),
        .overrun   (ovr),
        .did_pop   (popped)
    );

    rx_idle_timer #(.CNT_W(TMO_WIDTH)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .idle    (rx_idle),
        .restart (ch_valid || popped || flush),
        .limit   (cfg_timeout),
        .reached (tmo_hit)
    );

    always_comb begin
        st_ready   = (fill != '0);
        st_half    = (fill >= CNT_W'(HALF));
        st_full    = (fill == CNT_W'(FIFO_DEPTH));
        st_overrun = ovr;
        st_timeout = st_ready && tmo_hit;
        rd_data    = st_ready ? {{PAD_W{1'b0}}, head} : '0;
    end

endmodule

// File: rtl/rx_tagged_fifo_chk.sv
module rx_tagged_fifo_chk #(
    parameter int RD_WIDTH = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_rx_en,
    input logic                cfg_run,
    input logic                rd_en,
    input logic                flush,
    input logic [RD_WIDTH-1:0] rd_data,
    input logic                st_ready,
    input logic                st_half,
    input logic                st_full,
    input logic                st_overrun,
    input logic                st_timeout
);

    AST_GATED_NO_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rx_en && cfg_run) |=> !$rose(st_ready)); // R1

    AST_HALF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st_half |-> st_ready); // R8

    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> st_half); // R8

    AST_OVERRUN_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_overrun) |-> $past(st_full)); // R9

    AST_OVERRUN_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && rd_en && st_ready && !flush) |=> !st_overrun); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!st_ready && !st_overrun)); // R10

    AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st_timeout |-> st_ready); // R11

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (rd_data == '0)); // R13

endmodule

bind rx_tagged_fifo rx_tagged_fifo_chk #(.RD_WIDTH(RD_WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rx_en  (cfg_rx_en),
    .cfg_run    (cfg_run),
    .rd_en      (rd_en),
    .flush      (flush),
    .rd_data    (rd_data),
    .st_ready   (st_ready),
    .st_half    (st_half),
    .st_full    (st_full),
    .st_overrun (st_overrun),
    .st_timeout (st_timeout)
);

// File: tb/rx_tagged_fifo_test.sv
module rx_tagged_fifo_test;

    localparam int BIT_CLK = 32;   // tick every 2 clocks, 16 ticks per bit
    localparam logic [2:0] M8  = 3'b001;
    localparam logic [2:0] M7P = 3'b011;
    localparam logic [2:0] M9  = 3'b100;
    localparam logic [2:0] M8W = 3'b101;
    localparam logic [2:0] M8P = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        rxd_pin = 1'b1;
    logic        txd_loop = 1'b1;
    logic        cfg_loop = 1'b0;
    logic        cfg_rx_en = 1'b1;
    logic        cfg_run = 1'b0;
    logic [2:0]  cfg_mode = 3'b001;
    logic        cfg_odd = 1'b0;
    logic [7:0]  cfg_timeout = 8'd8;
    logic        mon_rd = 1'b0;
    logic        tb_rd = 1'b0;
    logic        rd_en;
    logic        flush = 1'b0;
    logic [15:0] rd_data;
    logic        st_ready, st_half, st_full, st_overrun, st_timeout;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    assign rd_en = mon_rd | tb_rd;

    always #10 clk = ~clk;

    rx_tagged_fifo uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_pin(rxd_pin),
        .txd_loop(txd_loop), .cfg_loop(cfg_loop), .cfg_rx_en(cfg_rx_en),
        .cfg_run(cfg_run), .cfg_mode(cfg_mode), .cfg_odd(cfg_odd),
        .cfg_timeout(cfg_timeout), .rd_en(rd_en), .flush(flush),
        .rd_data(rd_data), .st_ready(st_ready), .st_half(st_half),
        .st_full(st_full), .st_overrun(st_overrun), .st_timeout(st_timeout)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [2:0] m, input logic [8:0] dv,
                                             input logic odd, input logic bp, input logic bs);
        logic [15:0] w;
        w = '0;
        case (m)
            M7P: begin
                w[6:0] = dv[6:0];
                w[7]   = (^dv[6:0]) ^ odd ^ bp;
                w[8]   = bp;
            end
            M8P:      w[7:0] = dv[7:0];
            M9, M8W:  w[8:0] = dv;
            default:  w[7:0] = dv[7:0];
        endcase
        w[9] = bs;
        return w;
    endfunction

    task automatic drive_bit(input logic b, input logic via_loop);
        if (via_loop) txd_loop = b;
        else          rxd_pin  = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] m, input logic [8:0] dv, input logic odd,
                              input logic bp, input logic bs, input logic via_loop);
        int  nb;
        bit  hp;
        logic p;
        nb = (m == M7P) ? 7 : ((m == M9 || m == M8W) ? 9 : 8);
        hp = (m == M7P) || (m == M8P);
        p  = ((nb == 7) ? (^dv[6:0]) : (^dv[7:0])) ^ odd ^ bp;
        drive_bit(1'b0, via_loop);
        for (int i = 0; i < nb; i++) drive_bit(dv[i], via_loop);
        if (hp) drive_bit(p, via_loop);
        drive_bit(!bs, via_loop);
        drive_bit(1'b1, via_loop);
    endtask

    // Scoreboard driver: record the expected word, then send the frame
    task automatic expect_frame(input string tag, input logic [2:0] m, input logic [8:0] dv,
                                input logic odd, input logic bp, input logic bs,
                                input logic via_loop);
        cfg_mode = m;
        cfg_odd  = odd;
        exp_q.push_back(exp_word(m, dv, odd, bp, bs));
        tag_q.push_back(tag);
        send_frame(m, dv, odd, bp, bs, via_loop);
    endtask

    // Monitor: pops the queue whenever data is waiting and compares
    initial begin
        forever begin
            @(negedge clk);
            if (mon_rd) begin
                mon_rd = 1'b0;
            end else if (mon_on && st_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7", "unexpected extra word", rd_data, 16'hxxxx);
                end else begin
                    check(tag_q.pop_front(), "scoreboard word", rd_data, exp_q.pop_front());
                end
                mon_rd = 1'b1;
            end
        end
    end

    task automatic drain(input string req);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4 * BIT_CLK) @(negedge clk);
        check(req, "queue empty after drain", {15'd0, st_ready}, 16'd0);
    endtask

    task automatic pop_check(input string req, input logic [15:0] exp);
        check(req, "head word", rd_data, exp);
        tb_rd = 1'b1;
        @(negedge clk);
        tb_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Reset state
        check("R8",  "ready after reset",   {15'd0, st_ready},   16'd0);
        check("R8",  "half after reset",    {15'd0, st_half},    16'd0);
        check("R8",  "full after reset",    {15'd0, st_full},    16'd0);
        check("R9",  "overrun after reset", {15'd0, st_overrun}, 16'd0);
        check("R11", "timeout after reset", {15'd0, st_timeout}, 16'd0);
        check("R13", "rd_data after reset", rd_data,             16'd0);

        // R1: run low, frame ignored
        send_frame(M8, 9'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (BIT_CLK) @(negedge clk);
        check("R1", "no word while run low", {15'd0, st_ready}, 16'd0);
        cfg_run = 1'b1;
        cfg_rx_en = 1'b0;
        send_frame(M8, 9'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", "no word while rx disabled", {15'd0, st_ready}, 16'd0);
        cfg_rx_en = 1'b1;
        repeat (BIT_CLK) @(negedge clk);

        // R2: short low glitch of 4 ticks
        rxd_pin = 1'b0;
        repeat (8) @(negedge clk);
        rxd_pin = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        check("R2", "glitch rejected", {15'd0, st_ready}, 16'd0);

        // Scoreboarded traffic
        mon_on = 1'b1;
        expect_frame("R3", M8, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R3", M8, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R3", M8, 9'h0FF, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R3", M8, 9'h03C, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R4", M7P, 9'h055, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R4", M7P, 9'h02A, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_frame("R4", M7P, 9'h013, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_frame("R4", M7P, 9'h061, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_frame("R5", M8P, 9'h0C3, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R5", M8P, 9'h0C3, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_frame("R6", M9,  9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R6", M8W, 9'h100, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R7", M8,  9'h05A, 1'b0, 1'b0, 1'b1, 1'b0);

        // R7: break, one word only
        cfg_mode = M8;
        exp_q.push_back(16'h0200);
        tag_q.push_back("R7");
        rxd_pin = 1'b0;
        repeat (20 * BIT_CLK) @(negedge clk);
        rxd_pin = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        expect_frame("R7", M8, 9'h077, 1'b0, 1'b0, 1'b0, 1'b0);

        // R12: loopback, pin held low and ignored
        cfg_loop = 1'b1;
        repeat (4) @(negedge clk);
        rxd_pin = 1'b0;
        expect_frame("R12", M8, 9'h081, 1'b0, 1'b0, 1'b0, 1'b1);
        rxd_pin = 1'b1;
        repeat (8) @(negedge clk);
        cfg_loop = 1'b0;
        drain("R7");
        mon_on = 1'b0;

        // R8/R9: fill, overrun, order
        cfg_mode = M8;
        for (int i = 0; i < 16; i++) begin
            send_frame(M8, 9'(i), 1'b0, 1'b0, 1'b0, 1'b0);
            if (i == 6) check("R8", "half at 7 words", {15'd0, st_half}, 16'd0);
            if (i == 7) check("R8", "half at 8 words", {15'd0, st_half}, 16'd1);
            if (i == 14) check("R8", "full at 15 words", {15'd0, st_full}, 16'd0);
        end
        check("R8", "full at 16 words", {15'd0, st_full}, 16'd1);
        check("R9", "no overrun at 16", {15'd0, st_overrun}, 16'd0);
        send_frame(M8, 9'h0EE, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9", "overrun set", {15'd0, st_overrun}, 16'd1);
        check("R9", "still full", {15'd0, st_full}, 16'd1);
        pop_check("R8", 16'h0000);
        check("R9", "overrun cleared by read", {15'd0, st_overrun}, 16'd0);
        pop_check("R8", 16'h0001);
        send_frame(M8, 9'h042, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(M8, 9'h043, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", "refilled", {15'd0, st_full}, 16'd1);
        send_frame(M8, 9'h044, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9", "overrun again", {15'd0, st_overrun}, 16'd1);
        for (int i = 2; i < 16; i++) pop_check("R9", 16'(i));
        pop_check("R9", 16'h0042);
        pop_check("R9", 16'h0043);
        check("R9", "dropped words absent", {15'd0, st_ready}, 16'd0);
        check("R13", "empty word zero", rd_data, 16'd0);

        // R10: flush
        send_frame(M8, 9'h011, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(M8, 9'h022, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "data before flush", {15'd0, st_ready}, 16'd1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R10", "empty after flush", {15'd0, st_ready}, 16'd0);
        check("R13", "word zero after flush", rd_data, 16'd0);

        // R11: idle timeout, 8 bit times
        cfg_timeout = 8'd8;
        send_frame(M8, 9'h0A1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(M8, 9'h0A2, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11", "no timeout right after arrival", {15'd0, st_timeout}, 16'd0);
        repeat (10 * BIT_CLK) @(negedge clk);
        check("R11", "timeout after idle", {15'd0, st_timeout}, 16'd1);
        pop_check("R11", 16'h00A1);
        check("R11", "read restarts count", {15'd0, st_timeout}, 16'd0);
        repeat (10 * BIT_CLK) @(negedge clk);
        check("R11", "timeout again", {15'd0, st_timeout}, 16'd1);
        pop_check("R11", 16'h00A2);
        check("R11", "no timeout when empty", {15'd0, st_timeout}, 16'd0);

        finish_run();
    end

endmodule